// File: doc/BRIEF.md
# Flash command sequence decoder

This block sits behind the host write port of a NOR-style flash device. It watches every bus write, each carrying an address and a 16-bit data word, and tracks the multi-write unlock-and-command sequences the host uses to request work from the device. When a sequence completes, it raises a single-cycle request to the embedded controller. The possible requests are word program, chip erase, sector erase, boot-region protection enable, identification-mode entry and identification-mode exit. Program and erase requests also present the address and data of the final write.

Every command starts with the same two-write unlock pair. The third write picks a branch. The program branch takes one more write, which is the target. The erase and protection branch takes a setup code and then repeats the unlock pair before its final code. A write that does not fit the expected step sends the decoder back to idle. While the embedded controller reports that it is busy, writes are ignored.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While reset is asserted (active-low, asynchronous), all request outputs are low, `req_addr` and `req_data` are zero, and any partial sequence is abandoned. A sequence interrupted by reset does not complete after reset is released.
- R2: The unlock pair is data low byte 0xAA at address 0x5555, then low byte 0x55 at address 0x2AAA. Only data bits 7:0 are compared, and only address bits 14:0 are compared.
- R3: After the unlock pair, low byte 0xA0 at 0x5555 followed by any fourth write raises `req_prog`. `req_addr` and `req_data` then show that fourth write's full address and data.
- R4: After the unlock pair, the writes 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA and then 0x10@0x5555 raise `req_chip_erase`.
- R5: The same six-write form ending in 0x30 at any address raises `req_sector_erase`, and `req_addr` shows that final write's address.
- R6: The same six-write form ending in 0x40@0x5555 raises `req_protect`.
- R7: After the unlock pair, 0x90@0x5555 raises `req_id_enter`.
- R8: A write with low byte 0xF0 at any address raises `req_id_exit`. This holds in every sequence position except the program data step, so it also covers the three-write exit form.
- R9: A write that does not match the expected step returns the decoder to idle, and it raises no request. Matching 0x10 or 0x40 at an address other than 0x5555 in the final erase step counts as a mismatch.
- R10: A write made while `busy` is high raises no request and leaves the sequence position unchanged.
- R11: Each request is a one-cycle pulse and at most one request is high at a time. `req_addr` and `req_data` change only when a request fires.
- R12: A program data word whose low byte is 0xF0 is taken as program data and not as an exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | A host write is present this cycle |
| wr_addr | input | 18 | Write address |
| wr_data | input | 16 | Write data |
| busy | input | 1 | An embedded program or erase is running |
| req_prog | output | 1 | Word program request pulse |
| req_chip_erase | output | 1 | Chip erase request pulse |
| req_sector_erase | output | 1 | Sector erase request pulse |
| req_protect | output | 1 | Protection enable request pulse |
| req_id_enter | output | 1 | Identification-mode entry pulse |
| req_id_exit | output | 1 | Identification-mode exit pulse |
| req_addr | output | 18 | Address of the write that fired the last request |
| req_data | output | 16 | Data of the write that fired the last request |

## Verification
A write is captured at the rising edge where `wr_en` is high. Its request, address and data become visible right after that edge and stay for exactly one cycle. The bench therefore drives each write on a falling edge and samples the outputs on the next falling edge, which is the middle of the pulse cycle. One idle cycle separates consecutive writes, and the bench samples again there to confirm that the pulse has dropped. Writes that should be ignored are followed by a completing sequence, which shows whether the sequence position survived them.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_PROG, ST_SETUP, ST_ERU1, ST_ERU2
  } seq_state_t;

  typedef enum logic [2:0] {
    RQ_NONE, RQ_PROG, RQ_CHIP, RQ_SECT, RQ_PROT, RQ_IDIN, RQ_IDOUT
  } req_kind_t;

  localparam int unsigned REQ_N = 6;

  localparam logic [7:0] CODE_KEY_A  = 8'hAA;
  localparam logic [7:0] CODE_KEY_B  = 8'h55;
  localparam logic [7:0] CODE_PROG   = 8'hA0;
  localparam logic [7:0] CODE_SETUP  = 8'h80;
  localparam logic [7:0] CODE_IDIN   = 8'h90;
  localparam logic [7:0] CODE_IDOUT  = 8'hF0;
  localparam logic [7:0] CODE_CHIP   = 8'h10;
  localparam logic [7:0] CODE_SECT   = 8'h30;
  localparam logic [7:0] CODE_PROT   = 8'h40;

  localparam logic [31:0] ADR_KEY_A = 32'h0000_5555;
  localparam logic [31:0] ADR_KEY_B = 32'h0000_2AAA;

  // Compare only the low w bits of two addresses.
  function automatic logic addr_match(logic [31:0] a, logic [31:0] pat,
                                      int unsigned w);
    logic [31:0] mask;
    mask = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    return ((a ^ pat) & mask) == 32'd0;
  endfunction

  // Request kind to one-hot vector: bit 0 program ... bit 5 id exit.
  function automatic logic [REQ_N-1:0] kind_to_vec(req_kind_t k);
    logic [REQ_N-1:0] v;
    v = '0;
    if (k != RQ_NONE) v[int'(k) - 1] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/fcd_classify.sv
module fcd_classify
  import fcd_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned CMP_W  = 15
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              at_key_a,
  output logic              at_key_b
);
  logic [31:0] addr_ext;

  assign addr_ext = 32'(addr);
  assign at_key_a = addr_match(addr_ext, ADR_KEY_A, CMP_W);
  assign at_key_b = addr_match(addr_ext, ADR_KEY_B, CMP_W);
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import fcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic       at_key_a,
  input  logic       at_key_b,
  input  logic [7:0] code,
  output seq_state_t state,
  output req_kind_t  kind
);
  seq_state_t nxt;

  always_comb begin
    nxt  = state;
    kind = RQ_NONE;
    if (fire) begin
      if (state == ST_PROG) begin
        kind = RQ_PROG;
        nxt  = ST_IDLE;
      end else if (code == CODE_IDOUT) begin
        kind = RQ_IDOUT;
        nxt  = ST_IDLE;
      end else begin
        nxt = ST_IDLE;
        case (state)
          ST_IDLE:  if (at_key_a && code == CODE_KEY_A) nxt = ST_UNL1;
          ST_UNL1:  if (at_key_b && code == CODE_KEY_B) nxt = ST_UNL2;
          ST_UNL2: begin
            if (at_key_a) begin
              if (code == CODE_PROG)       nxt  = ST_PROG;
              else if (code == CODE_SETUP) nxt  = ST_SETUP;
              else if (code == CODE_IDIN)  kind = RQ_IDIN;
            end
          end
          ST_SETUP: if (at_key_a && code == CODE_KEY_A) nxt = ST_ERU1;
          ST_ERU1:  if (at_key_b && code == CODE_KEY_B) nxt = ST_ERU2;
          ST_ERU2: begin
            if (code == CODE_SECT)                   kind = RQ_SECT;
            else if (at_key_a && code == CODE_CHIP)  kind = RQ_CHIP;
            else if (at_key_a && code == CODE_PROT)  kind = RQ_PROT;
          end
          default: nxt = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/fcd_req_reg.sv
module fcd_req_reg
  import fcd_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  req_kind_t         kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [REQ_N-1:0]  req_vec,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_vec  <= '0;
      req_addr <= '0;
      req_data <= '0;
    end else begin
      req_vec <= kind_to_vec(kind);
      if (kind != RQ_NONE) begin
        req_addr <= addr;
        req_data <= data;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CMP_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  output logic              req_prog,
  output logic              req_chip_erase,
  output logic              req_sector_erase,
  output logic              req_protect,
  output logic              req_id_enter,
  output logic              req_id_exit,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data
);
  logic             wr_accept;
  logic             at_key_a;
  logic             at_key_b;
  logic [7:0]       wr_code;
  seq_state_t       seq_state;
  req_kind_t        req_kind;
  logic [REQ_N-1:0] req_vec;

  assign wr_accept = wr_en && !busy;
  assign wr_code   = wr_data[7:0];

  fcd_classify #(.ADDR_W(ADDR_W), .CMP_W(CMP_W)) u_classify (
    .addr     (wr_addr),
    .at_key_a (at_key_a),
    .at_key_b (at_key_b)
  );

  fcd_seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (wr_accept),
    .at_key_a (at_key_a),
    .at_key_b (at_key_b),
    .code     (wr_code),
    .state    (seq_state),
    .kind     (req_kind)
  );

  fcd_req_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .kind     (req_kind),
    .addr     (wr_addr),
    .data     (wr_data),
    .req_vec  (req_vec),
    .req_addr (req_addr),
    .req_data (req_data)
  );

  assign req_prog         = req_vec[0];
  assign req_chip_erase   = req_vec[1];
  assign req_sector_erase = req_vec[2];
  assign req_protect      = req_vec[3];
  assign req_id_enter     = req_vec[4];
  assign req_id_exit      = req_vec[5];
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker
  import fcd_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              busy,
  input logic              req_prog,
  input logic              req_chip_erase,
  input logic              req_sector_erase,
  input logic              req_protect,
  input logic              req_id_enter,
  input logic              req_id_exit,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_data,
  input seq_state_t        seq_state
);
  logic any_req;
  logic taken;

  assign any_req = req_prog | req_chip_erase | req_sector_erase |
                   req_protect | req_id_enter | req_id_exit;
  assign taken   = wr_en && !busy;

  AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_prog, req_chip_erase, req_sector_erase, req_protect,
              req_id_enter, req_id_exit})); // R11
  AST_REQ_FROM_TAKEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |-> $past(taken)); // R10
  AST_BUSY_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |=> $stable(seq_state)); // R10
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |=> ($stable(req_addr) && $stable(req_data))); // R11
  AST_PROG_CARRIES: assert property (@(posedge clk) disable iff (!rst_n)
    req_prog |-> (req_addr == $past(wr_addr) && req_data == $past(wr_data))); // R3
  AST_PROG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_prog |=> !req_prog); // R11
  AST_CHIP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    req_chip_erase |-> ($past(wr_data[7:0]) == CODE_CHIP)); // R4
  AST_SECT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    req_sector_erase |-> ($past(wr_data[7:0]) == CODE_SECT &&
                          req_addr == $past(wr_addr))); // R5
  AST_PROT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    req_protect |-> ($past(wr_data[7:0]) == CODE_PROT)); // R6
  AST_IDIN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    req_id_enter |-> ($past(wr_data[7:0]) == CODE_IDIN)); // R7
  AST_EXIT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    req_id_exit |-> ($past(wr_data[7:0]) == CODE_IDOUT)); // R8
endmodule

bind flash_cmd_decoder fcd_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .wr_en            (wr_en),
  .wr_addr          (wr_addr),
  .wr_data          (wr_data),
  .busy             (busy),
  .req_prog         (req_prog),
  .req_chip_erase   (req_chip_erase),
  .req_sector_erase (req_sector_erase),
  .req_protect      (req_protect),
  .req_id_enter     (req_id_enter),
  .req_id_exit      (req_id_exit),
  .req_addr         (req_addr),
  .req_data         (req_data),
  .seq_state        (seq_state)
);

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;
  localparam int AW = 18;
  localparam int DW = 16;
  // Expected request vector bits: {id_exit,id_enter,protect,sector,chip,prog}
  localparam logic [5:0] E_NONE = 6'b000000;
  localparam logic [5:0] E_PROG = 6'b000001;
  localparam logic [5:0] E_CHIP = 6'b000010;
  localparam logic [5:0] E_SECT = 6'b000100;
  localparam logic [5:0] E_PROT = 6'b001000;
  localparam logic [5:0] E_IDIN = 6'b010000;
  localparam logic [5:0] E_IDEX = 6'b100000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          busy = 1'b0;
  logic req_prog, req_chip_erase, req_sector_erase, req_protect;
  logic req_id_enter, req_id_exit;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;

  int n_vec = 0;
  int n_mis = 0;
  logic [5:0] snap;

  always #10 clk = ~clk;

  flash_cmd_decoder i_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .req_prog(req_prog),
    .req_chip_erase(req_chip_erase), .req_sector_erase(req_sector_erase),
    .req_protect(req_protect), .req_id_enter(req_id_enter),
    .req_id_exit(req_id_exit), .req_addr(req_addr), .req_data(req_data)
  );

  function automatic logic [5:0] reqs();
    return {req_id_exit, req_id_enter, req_protect, req_sector_erase,
            req_chip_erase, req_prog};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Write captured at the posedge between the two falling edges; the
  // pulse is sampled on the second falling edge.
  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    snap = reqs();
  endtask

  task automatic wr_chk(string tag, logic [AW-1:0] a, logic [DW-1:0] d,
                        logic [5:0] exp);
    wr(a, d);
    check(tag, 32'(snap), 32'(exp));
  endtask

  task automatic unlock(logic [AW-1:0] a1 = 18'h05555, logic [DW-1:0] d1 = 16'h00AA);
    wr_chk("R2 unlock1", a1, d1, E_NONE);
    wr_chk("R2 unlock2", 18'h02AAA, 16'h0055, E_NONE);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 reset reqs", 32'(reqs()), 32'(E_NONE));
    check("R1 reset addr", 32'(req_addr), 32'h0);
    check("R1 reset data", 32'(req_data), 32'h0);
    rst_n = 1'b1;
  endtask

  task automatic t_program();
    unlock();
    wr_chk("R3 prog setup", 18'h05555, 16'h00A0, E_NONE);
    wr_chk("R3 prog fire", 18'h12345, 16'hBEEF, E_PROG);
    check("R3 prog addr", 32'(req_addr), 32'h12345);
    check("R3 prog data", 32'(req_data), 32'hBEEF);
    @(negedge clk);
    check("R11 pulse ends", 32'(reqs()), 32'(E_NONE));
    check("R11 addr held", 32'(req_addr), 32'h12345);
  endtask

  task automatic t_program_f0();
    unlock();
    wr_chk("R12 setup", 18'h05555, 16'h00A0, E_NONE);
    wr_chk("R12 f0 is data", 18'h00040, 16'h00F0, E_PROG);
    check("R12 data", 32'(req_data), 32'h00F0);
  endtask

  task automatic t_upper_bits();
    unlock(18'h25555, 16'h12AA);
    wr_chk("R2 masked setup", 18'h3D555, 16'hFFA0, E_NONE);
    wr_chk("R2 masked prog", 18'h00007, 16'h0001, E_PROG);
  endtask

  task automatic erase_head();
    unlock();
    wr_chk("R4 setup80", 18'h05555, 16'h0080, E_NONE);
    unlock();
  endtask

  task automatic t_erases();
    erase_head();
    wr_chk("R4 chip erase", 18'h05555, 16'h0010, E_CHIP);
    erase_head();
    wr_chk("R5 sector erase", 18'h05123, 16'h0030, E_SECT);
    check("R5 sector addr", 32'(req_addr), 32'h05123);
    erase_head();
    wr_chk("R6 protect", 18'h05555, 16'h0040, E_PROT);
  endtask

  task automatic t_id();
    unlock();
    wr_chk("R7 id enter", 18'h05555, 16'h0090, E_IDIN);
    wr_chk("R8 lone exit", 18'h01234, 16'h00F0, E_IDEX);
    unlock();
    wr_chk("R8 three-write exit", 18'h05555, 16'h00F0, E_IDEX);
  endtask

  task automatic t_mismatch();
    wr_chk("R9 key a", 18'h05555, 16'h00AA, E_NONE);
    wr_chk("R9 bad key b", 18'h02AAA, 16'h0056, E_NONE);
    wr_chk("R9 stray b", 18'h02AAA, 16'h0055, E_NONE);
    wr_chk("R9 stray a0", 18'h05555, 16'h00A0, E_NONE);
    wr_chk("R9 no prog", 18'h00100, 16'h1234, E_NONE);
    erase_head();
    wr_chk("R9 chip wrong addr", 18'h01000, 16'h0010, E_NONE);
    wr_chk("R9 idle after", 18'h05555, 16'h0010, E_NONE);
  endtask

  task automatic t_busy();
    unlock();
    busy = 1'b1;
    wr_chk("R10 busy setup", 18'h05555, 16'h0011, E_NONE);
    wr_chk("R10 busy f0", 18'h05555, 16'h00F0, E_NONE);
    busy = 1'b0;
    wr_chk("R10 resume setup", 18'h05555, 16'h00A0, E_NONE);
    wr_chk("R10 resume prog", 18'h00321, 16'h5A5A, E_PROG);
  endtask

  task automatic t_reset_mid();
    unlock();
    wr_chk("R1 pre-reset setup", 18'h05555, 16'h00A0, E_NONE);
    do_reset();
    wr_chk("R1 no prog after reset", 18'h00011, 16'h7777, E_NONE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 initial reqs", 32'(reqs()), 32'(E_NONE));
    check("R1 initial addr", 32'(req_addr), 32'h0);
    rst_n = 1'b1;
    t_program();
    t_program_f0();
    t_upper_bits();
    t_erases();
    t_id();
    t_mismatch();
    t_busy();
    t_reset_mid();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_mis);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_mis++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_mis);
    $finish;
  end
endmodule